// File: doc/BRIEF.md
# Bit-Serial Montgomery Modular Multiplier

This block computes the Montgomery product A·B·2^-n mod M for an n-bit odd modulus M, one bit of the multiplier operand A per clock cycle. A host raises a one-cycle start strobe with A, B and M on the operand inputs. The block captures them and keeps its partial remainder as three redundant vectors: a sum vector and two carry vectors. No carry has to ripple across the word inside an iteration, so the loop's critical path is two full-adder levels deep whatever the width.

After n iterations a single resolve cycle adds the three vectors with a carry-propagate adder. That cycle also subtracts M once if the total is not already below it, and raises a one-cycle done pulse with the reduced result. Operands must satisfy 0 < A, B < M and 2^(n-1) < M < 2^n with M odd. Sequencing several products, for example into an exponentiation, and precomputing the domain-conversion constant are left to the caller.

Top module: `mont_mul`

## Requirements
- R1: For valid operands, the result presented with done equals the unique value r in [0, M) with r·2^WIDTH ≡ A·B (mod M).
- R2: The result presented with done is strictly below the captured modulus M.
- R3: A start seen while idle is accepted on that clock edge. busy_o is high from the next cycle until done_o rises, and done_o rises WIDTH+1 cycles after the accepting edge.
- R4: done_o is high for exactly one cycle per accepted operation.
- R5: res_o changes only in the cycle in which done_o is high, and otherwise holds its last value until the next completion.
- R6: A start asserted while busy_o is high is ignored: the operands in flight and the completion time are unaffected.
- R7: While rst_ni is low, busy_o and done_o are low and res_o is zero, including when reset interrupts an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled only while idle |
| a_i | input | WIDTH | Multiplier operand A, consumed LSB first |
| b_i | input | WIDTH | Multiplicand operand B |
| m_i | input | WIDTH | Odd modulus M with top bit set |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| res_o | output | WIDTH | Montgomery product, valid from done |

## Verification
The product is due WIDTH+1 cycles after the clock edge that accepts start. busy_o is due one cycle after that edge, and done_o falls one cycle after it rises. The bench drives every input on falling edges and counts edges from the accepting one. At each intermediate falling edge it confirms done_o is still low. It reads done_o and res_o at the falling edge after edge WIDTH+1, then once more one cycle later to see done_o drop and the result hold. Expected products come from a brute-force search for r with r·2^WIDTH ≡ A·B (mod M), so they share nothing with the iteration in the design.

// File: rtl/mont_pkg.sv
package mont_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mont_state_e;
endpackage

// File: rtl/mont_csa.sv
// 3:2 compressor: x + y + z == s_o + c_o (carry pre-shifted by one)
module mont_csa #(
  parameter int W = 10
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);
  logic [W-1:0] maj;

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign s_o[g] = x_i[g] ^ y_i[g] ^ z_i[g];
    assign maj[g] = (x_i[g] & y_i[g]) | (x_i[g] & z_i[g]) | (y_i[g] & z_i[g]);
  end

  assign c_o = {maj[W-2:0], 1'b0};

  // top carry cannot be set while total < 2^W
  logic unused_top;
  assign unused_top = maj[W-1];
endmodule

// File: rtl/mont_iter.sv
// One radix-2 iteration on the redundant remainder
module mont_iter #(
  parameter int WIDTH = 8,
  localparam int AW = WIDTH + 2
) (
  input  logic [AW-1:0]    s_i,
  input  logic [AW-1:0]    c1_i,
  input  logic [AW-1:0]    c2_i,
  input  logic             abit_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] m_i,
  output logic [AW-1:0]    s_o,
  output logic [AW-1:0]    c1_o,
  output logic [AW-1:0]    c2_o
);
  logic          q;
  logic [AW-1:0] pp, qm;
  logic [AW-1:0] t_s, t_c, u_s, u_c;

  assign q  = s_i[0] ^ c1_i[0] ^ c2_i[0] ^ (abit_i & b_i[0]);
  assign pp = abit_i ? {2'b00, b_i} : '0;
  assign qm = q ? {2'b00, m_i} : '0;

  mont_csa #(.W(AW)) u_csa_a (
    .x_i(s_i), .y_i(c1_i), .z_i(pp), .s_o(t_s), .c_o(t_c)
  );
  mont_csa #(.W(AW)) u_csa_b (
    .x_i(t_s), .y_i(c2_i), .z_i(qm), .s_o(u_s), .c_o(u_c)
  );

  // total is even by choice of q: exact halving of each vector
  assign s_o  = {1'b0, u_s[AW-1:1]};
  assign c1_o = {1'b0, t_c[AW-1:1]};
  assign c2_o = {1'b0, u_c[AW-1:1]};

  logic unused_lsb;
  assign unused_lsb = u_s[0] ^ t_c[0] ^ u_c[0];
endmodule

// File: rtl/mont_resolve.sv
// Carry-propagate merge of the three vectors plus one conditional subtract
module mont_resolve #(
  parameter int WIDTH = 8,
  localparam int AW = WIDTH + 2
) (
  input  logic [AW-1:0]    s_i,
  input  logic [AW-1:0]    c1_i,
  input  logic [AW-1:0]    c2_i,
  input  logic [WIDTH-1:0] m_i,
  output logic [WIDTH-1:0] r_o
);
  logic [AW-1:0] sum, diff, m_ext, sel;

  assign m_ext = {2'b00, m_i};
  assign sum   = s_i + c1_i + c2_i;
  assign diff  = sum - m_ext;
  assign sel   = (sum >= m_ext) ? diff : sum;
  assign r_o   = sel[WIDTH-1:0];

  logic unused_hi;
  assign unused_hi = ^sel[AW-1:WIDTH];
endmodule

// File: rtl/mont_ctrl.sv
module mont_ctrl
  import mont_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic accept_o,
  output logic run_o,
  output logic fin_o,
  output logic busy_o
);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  mont_state_e   state_q;
  logic [CW-1:0] cnt_q;

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign run_o    = (state_q == ST_RUN);
  assign fin_o    = (state_q == ST_FIN);
  assign busy_o   = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          if (cnt_q == LAST) state_q <= ST_FIN;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mont_mul.sv
module mont_mul #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] m_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] res_o
);
  localparam int AW = WIDTH + 2;

  logic             accept, run, fin;
  logic [WIDTH-1:0] a_sh, b_q, m_q, res_q, res_nx;
  logic [AW-1:0]    s_q, c1_q, c2_q, s_nx, c1_nx, c2_nx;
  logic             done_q;

  mont_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .run_o    (run),
    .fin_o    (fin),
    .busy_o   (busy_o)
  );

  mont_iter #(.WIDTH(WIDTH)) u_iter (
    .s_i    (s_q),
    .c1_i   (c1_q),
    .c2_i   (c2_q),
    .abit_i (a_sh[0]),
    .b_i    (b_q),
    .m_i    (m_q),
    .s_o    (s_nx),
    .c1_o   (c1_nx),
    .c2_o   (c2_nx)
  );

  mont_resolve #(.WIDTH(WIDTH)) u_res (
    .s_i  (s_q),
    .c1_i (c1_q),
    .c2_i (c2_q),
    .m_i  (m_q),
    .r_o  (res_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_sh <= '0;
      b_q  <= '0;
      m_q  <= '0;
      s_q  <= '0;
      c1_q <= '0;
      c2_q <= '0;
    end else if (accept) begin
      a_sh <= a_i;
      b_q  <= b_i;
      m_q  <= m_i;
      s_q  <= '0;
      c1_q <= '0;
      c2_q <= '0;
    end else if (run) begin
      a_sh <= a_sh >> 1;
      s_q  <= s_nx;
      c1_q <= c1_nx;
      c2_q <= c2_nx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= fin;
      if (fin) res_q <= res_nx;
    end
  end

  assign done_o = done_q;
  assign res_o  = res_q;
endmodule

// File: rtl/mont_mul_chk.sv
module mont_mul_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [WIDTH-1:0] m_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] res_o
);
  logic             acc;
  logic [31:0]      lat_cnt;
  logic [WIDTH-1:0] m_lat;

  assign acc = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_cnt <= '0;
      m_lat   <= '0;
    end else if (acc) begin
      lat_cnt <= '0;
      m_lat   <= m_i;
    end else if (busy_o) begin
      lat_cnt <= lat_cnt + 32'd1;
    end
  end

  p_lt_m_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (res_o < m_lat));

  p_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_cnt == 32'(WIDTH + 1)));

  p_accept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (busy_o && !done_o));

  p_busy_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(res_o));
endmodule

bind mont_mul mont_mul_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_mont_mul.sv
module sim_mont_mul;
  localparam int W  = 8;
  localparam int NV = 8;

  // stimulus table: valid operands, M odd with top bit set
  localparam logic [W-1:0] VA [NV] = '{8'd5,   8'd200, 8'd128, 8'd254, 8'd1,   8'd129, 8'd250, 8'd77};
  localparam logic [W-1:0] VB [NV] = '{8'd7,   8'd100, 8'd128, 8'd254, 8'd1,   8'd2,   8'd3,   8'd190};
  localparam logic [W-1:0] VM [NV] = '{8'd131, 8'd251, 8'd129, 8'd255, 8'd129, 8'd133, 8'd253, 8'd199};

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0, m_i = '0;
  logic         busy_o, done_o;
  logic [W-1:0] res_o;

  int errors = 0;
  int checks = 0;

  always #5 clk_i = ~clk_i;

  mont_mul #(.WIDTH(W)) u0 (
    .clk_i, .rst_ni, .start_i, .a_i, .b_i, .m_i, .busy_o, .done_o, .res_o
  );

  function automatic int unsigned exp_mm(int unsigned a, int unsigned b, int unsigned m);
    longint unsigned t;
    t = (longint'(a) * longint'(b)) % longint'(m);
    for (int unsigned r = 0; r < m; r++)
      if (((longint'(r) << W) % longint'(m)) == t) return r;
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one operation; optionally pulse start with other operands mid-run
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] m, input bit poke);
    int unsigned e;
    int          early;
    e = exp_mm(a, b, m);
    early = 0;
    @(negedge clk_i);
    start_i = 1'b1; a_i = a; b_i = b; m_i = m;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o === 1'b1, "R3 busy after accept", int'(busy_o), 1);
    for (int k = 1; k <= W; k++) begin
      @(negedge clk_i);
      if (poke && k == 3) begin
        start_i = 1'b1; a_i = 8'd1; b_i = 8'd1; m_i = 8'd131;   // R6 stimulus
      end else begin
        start_i = 1'b0;
      end
      if (done_o !== 1'b0) early++;
    end
    start_i = 1'b0;
    check(early == 0, "R3 done not early", early, 0);
    @(negedge clk_i);
    check(done_o === 1'b1, "R3 done at WIDTH+1", int'(done_o), 1);
    check(res_o == W'(e), poke ? "R6 result of first operands" : "R1 product", int'(res_o), int'(e));
    check(res_o < m, "R2 below modulus", int'(res_o), int'(m));
    @(negedge clk_i);
    check(done_o === 1'b0, "R4 single pulse", int'(done_o), 0);
    check(busy_o === 1'b0, "R3 busy cleared", int'(busy_o), 0);
    check(res_o == W'(e), "R5 result held", int'(res_o), int'(e));
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    // R7: reset state
    check(busy_o === 1'b0, "R7 busy in reset", int'(busy_o), 0);
    check(done_o === 1'b0, "R7 done in reset", int'(done_o), 0);
    check(res_o == '0, "R7 res in reset", int'(res_o), 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) run_op(VA[i], VB[i], VM[i], 1'b0);

    // R5: idle cycles keep the last result
    repeat (5) @(negedge clk_i);
    check(res_o == W'(exp_mm(VA[NV-1], VB[NV-1], VM[NV-1])), "R5 held while idle",
          int'(res_o), int'(exp_mm(VA[NV-1], VB[NV-1], VM[NV-1])));

    // R6: start while busy ignored
    run_op(8'd201, 8'd150, 8'd223, 1'b1);

    // R7: reset in the middle of an operation
    @(negedge clk_i);
    start_i = 1'b1; a_i = 8'd99; b_i = 8'd45; m_i = 8'd241;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(busy_o === 1'b0, "R7 busy after mid-run reset", int'(busy_o), 0);
    check(done_o === 1'b0, "R7 done after mid-run reset", int'(done_o), 0);
    check(res_o == '0, "R7 res after mid-run reset", int'(res_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: boundary operands after reset recovery
    run_op(8'd136, 8'd136, 8'd137, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule